// File: doc/BRIEF.md
# USB Device Mode Command Sequencer

This block holds the command bits of a USB device controller's one-byte mode register and turns software writes into control actions. Four bits matter. Three of them are commands: send-resume, go-suspend and soft-reset. Software arms a command by writing 1 to its bit and fires it by writing 0 afterwards. A bit that is written 1 and stays 1 does nothing. The fourth bit, wake-on-chip-select, is a plain enable.

A fired resume waits 5 ms and then drives the upstream resume request for 10 ms. A status output stays high for the whole sequence. Go-suspend raises a suspend request, and any register read or the start of a resume lowers it. If the wake enable is set, a read that arrives while the block is suspended also asks the clock generator to restart. Soft-reset sends a one-cycle pulse to the reset distribution, which leaves the suspend state and stops any resume in progress.

Writes that arrive while the clock is not yet reported stable are dropped, and each one is flagged. The millisecond timings come from a clock-frequency parameter. The line signalling, the clock generator and the reset tree are outside this block.

Top module: `mode_cmd_seq`

## Requirements
- R1: After reset, mode_q and every output read 0. An accepted write appears on mode_q on the next cycle. Only bit 7 (send-resume), bit 6 (go-suspend), bit 5 (soft-reset) and bit 2 (wake enable) are stored. All other bits, including reserved bits 1:0, read 0.
- R2: A write made while clk_stable is 0 leaves mode_q unchanged and fires no command. It raises wr_error for exactly the following cycle.
- R3: A command fires only when an accepted write takes its stored bit from 1 to 0. Writing 1 over a stored 1 fires nothing.
- R4: A send-resume fire raises resume_busy on the next cycle. resume_drive rises 5 ms (CLK_FREQ_HZ/1000*5 cycles) after resume_busy, stays high for 10 ms, and then falls together with resume_busy.
- R5: A send-resume fire while resume_busy is 1 is ignored, and the running sequence keeps its timing.
- R6: A go-suspend fire sets suspend_req on the next cycle.
- R7: A read strobe, or the start of a resume sequence, clears suspend_req on the next cycle.
- R8: A read while suspend_req is 1 and wake-enable bit 2 is 1 gives a one-cycle clk_wake_req on the next cycle. With bit 2 at 0 the read gives no request.
- R9: A soft-reset fire gives a single-cycle soft_reset_pulse on the next cycle. In that same cycle suspend_req, resume_busy and resume_drive are 0.
- R10: When one write fires soft-reset together with other commands, soft-reset takes priority. No suspend is entered and no resume starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| clk_stable | input | 1 | Clock reported stable; writes are accepted only when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| mode_q | output | 8 | Stored register image |
| wr_error | output | 1 | One-cycle flag for a write that was dropped |
| suspend_req | output | 1 | Suspend request state |
| clk_wake_req | output | 1 | One-cycle request to restart the chip clock |
| soft_reset_pulse | output | 1 | One-cycle soft reset to the reset distribution |
| resume_busy | output | 1 | Resume sequence in progress (delay or drive) |
| resume_drive | output | 1 | Upstream resume drive request |

## Verification
The hardest case to reach is a soft-reset that arrives in the middle of a resume while the block is also suspended. Only writes can get there, and each write has to keep the right arming bits set so that it does not fire a command by accident. The stimulus first arms and fires resume, then arms suspend and soft-reset in a write that fires nothing, then fires suspend, and last fires soft-reset. Each step keeps bit 5 at 1 until the final write. A second path fires a resume while one is already running, to show that the delay and drive windows keep their original edges.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
  localparam int REG_W       = 8;
  localparam int BIT_RESUME  = 7;
  localparam int BIT_SUSPEND = 6;
  localparam int BIT_SRST    = 5;
  localparam int BIT_WAKE    = 2;
  localparam logic [REG_W-1:0] STORE_MASK = 8'hE4;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_WAIT  = 2'd1,
    RS_DRIVE = 2'd2
  } rs_state_e;

  typedef struct packed {
    logic resume;
    logic suspend;
    logic srst;
  } cmd_fire_t;
endpackage

// File: rtl/mcs_cmd_reg.sv
`timescale 1ns/1ps
module mcs_cmd_reg
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_stable,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mode_q,
  output logic             wake_en,
  output cmd_fire_t        fire,
  output logic             wr_error
);
  logic             wr_ok;
  logic [REG_W-1:0] mode_d;
  logic             err_d;

  always_comb begin
    wr_ok        = wr_en & clk_stable;
    err_d        = wr_en & ~clk_stable;
    mode_d       = wr_ok ? (wr_data & STORE_MASK) : mode_q;
    fire.resume  = wr_ok & mode_q[BIT_RESUME]  & ~wr_data[BIT_RESUME];
    fire.suspend = wr_ok & mode_q[BIT_SUSPEND] & ~wr_data[BIT_SUSPEND];
    fire.srst    = wr_ok & mode_q[BIT_SRST]    & ~wr_data[BIT_SRST];
    wake_en      = mode_q[BIT_WAKE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      wr_error <= 1'b0;
    end else begin
      if (wr_ok) mode_q <= mode_d;
      wr_error <= err_d;
    end
  end

  AST_BAD_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clk_stable) |=> $stable(mode_q)); // R2
  AST_BAD_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clk_stable) |=> wr_error); // R2
  AST_NO_FIRE_UNSTABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_stable |-> (fire == '0)); // R2
endmodule

// File: rtl/mcs_resume_timer.sv
`timescale 1ns/1ps
module mcs_resume_timer
  import mcs_pkg::*;
#(
  parameter int DELAY_CYC = 5,
  parameter int DRIVE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_resume,
  input  logic abort,
  output logic start,
  output logic busy,
  output logic drive
);
  localparam int CNT_MAX = (DELAY_CYC > DRIVE_CYC) ? DELAY_CYC : DRIVE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYC - 1);

  rs_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = '0;
    cnt_en = 1'b0;
    start  = 1'b0;
    if (abort) begin
      st_d   = RS_IDLE;
      cnt_en = 1'b1;
    end else begin
      case (st_q)
        RS_IDLE: begin
          if (fire_resume) begin
            start  = 1'b1;
            st_d   = RS_WAIT;
            cnt_en = 1'b1;
          end
        end
        RS_WAIT: begin
          cnt_en = 1'b1;
          if (cnt_q == DELAY_LAST) st_d = RS_DRIVE;
          else                     cnt_d = cnt_q + 1'b1;
        end
        RS_DRIVE: begin
          cnt_en = 1'b1;
          if (cnt_q == DRIVE_LAST) st_d = RS_IDLE;
          else                     cnt_d = cnt_q + 1'b1;
        end
        default: begin
          st_d   = RS_IDLE;
          cnt_en = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy  = (st_q != RS_IDLE);
  assign drive = (st_q == RS_DRIVE);

  AST_BUSY_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fire_resume)); // R4
  AST_DRIVE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(busy)); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy); // R9
endmodule

// File: rtl/mcs_power_ctl.sv
`timescale 1ns/1ps
module mcs_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_suspend,
  input  logic fire_srst,
  input  logic resume_start,
  input  logic rd_en,
  input  logic wake_en,
  output logic suspend_req,
  output logic clk_wake_req,
  output logic soft_reset_pulse
);
  logic susp_d, wake_d, srst_d;

  always_comb begin
    susp_d = suspend_req;
    if (fire_srst)                   susp_d = 1'b0;
    else if (resume_start || rd_en)  susp_d = 1'b0;
    else if (fire_suspend)           susp_d = 1'b1;
    wake_d = rd_en & suspend_req & wake_en;
    srst_d = fire_srst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      suspend_req      <= 1'b0;
      clk_wake_req     <= 1'b0;
      soft_reset_pulse <= 1'b0;
    end else begin
      suspend_req      <= susp_d;
      clk_wake_req     <= wake_d;
      soft_reset_pulse <= srst_d;
    end
  end

  AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_pulse |=> !soft_reset_pulse); // R9
  AST_SRST_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_pulse |-> !suspend_req); // R9
  AST_READ_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !suspend_req); // R7
  AST_WAKE_FROM_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_wake_req |-> $past(suspend_req && rd_en)); // R8
endmodule

// File: rtl/mode_cmd_seq.sv
`timescale 1ns/1ps
module mode_cmd_seq
  import mcs_pkg::*;
#(
  parameter int CLK_FREQ_HZ     = 48_000_000,
  parameter int RESUME_DELAY_MS = 5,
  parameter int RESUME_DRIVE_MS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_stable,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] mode_q,
  output logic       wr_error,
  output logic       suspend_req,
  output logic       clk_wake_req,
  output logic       soft_reset_pulse,
  output logic       resume_busy,
  output logic       resume_drive
);
  localparam int CYC_PER_MS = CLK_FREQ_HZ / 1000;
  localparam int DELAY_CYC  = RESUME_DELAY_MS * CYC_PER_MS;
  localparam int DRIVE_CYC  = RESUME_DRIVE_MS * CYC_PER_MS;

  cmd_fire_t fire;
  logic      wake_en;
  logic      resume_start;

  mcs_cmd_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_stable (clk_stable),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .mode_q     (mode_q),
    .wake_en    (wake_en),
    .fire       (fire),
    .wr_error   (wr_error)
  );

  mcs_resume_timer #(
    .DELAY_CYC (DELAY_CYC),
    .DRIVE_CYC (DRIVE_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_resume (fire.resume),
    .abort       (fire.srst),
    .start       (resume_start),
    .busy        (resume_busy),
    .drive       (resume_drive)
  );

  mcs_power_ctl u_pwr (
    .clk              (clk),
    .rst_n            (rst_n),
    .fire_suspend     (fire.suspend),
    .fire_srst        (fire.srst),
    .resume_start     (resume_start),
    .rd_en            (rd_en),
    .wake_en          (wake_en),
    .suspend_req      (suspend_req),
    .clk_wake_req     (clk_wake_req),
    .soft_reset_pulse (soft_reset_pulse)
  );

  AST_SRST_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_pulse |-> (!resume_busy && !resume_drive)); // R9
  AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_q[1:0] == 2'b00)); // R1
endmodule

// File: tb/tb_mode_cmd_seq.sv
`timescale 1ns/1ps
module tb_mode_cmd_seq;
  localparam int FREQ  = 200_000;
  localparam int DELAY = 5 * (FREQ / 1000);
  localparam int DRIVE = 10 * (FREQ / 1000);

  localparam int S_MODE = 0, S_ERR = 1, S_SUSP = 2, S_WAKE = 3,
                 S_SRST = 4, S_BUSY = 5, S_DRV = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_stable = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] mode_q;
  logic       wr_error, suspend_req, clk_wake_req, soft_reset_pulse;
  logic       resume_busy, resume_drive;

  int cyc = 0;
  int checks = 0;
  int errs = 0;

  typedef struct {
    int         at;
    int         sig;
    logic [7:0] val;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mode_cmd_seq #(.CLK_FREQ_HZ(FREQ)) dut (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .mode_q(mode_q), .wr_error(wr_error),
    .suspend_req(suspend_req), .clk_wake_req(clk_wake_req),
    .soft_reset_pulse(soft_reset_pulse), .resume_busy(resume_busy),
    .resume_drive(resume_drive)
  );

  function automatic logic [7:0] get_sig(int s);
    case (s)
      S_MODE:  return mode_q;
      S_ERR:   return {7'd0, wr_error};
      S_SUSP:  return {7'd0, suspend_req};
      S_WAKE:  return {7'd0, clk_wake_req};
      S_SRST:  return {7'd0, soft_reset_pulse};
      S_BUSY:  return {7'd0, resume_busy};
      default: return {7'd0, resume_drive};
    endcase
  endfunction

  task automatic push(int at, int sig, logic [7:0] val, string req);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: pops expectations due this cycle and compares
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at <= cyc) begin
        logic [7:0] act;
        act = get_sig(sb[i].sig);
        checks++;
        if (sb[i].at < cyc || act !== sb[i].val) begin
          errs++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%h expected=%h",
                   sb[i].req, sb[i].sig, sb[i].at, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic do_write(input logic [7:0] d, output int n);
    @(negedge clk);
    n = cyc; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(output int n);
    @(negedge clk);
    n = cyc; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int n, r, tmp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r = cyc;
    for (int s = 0; s <= S_DRV; s++) push(r + 1, s, 8'h00, "R1 reset");

    do_write(8'hFF, n);                       // R1 masked storage
    push(n + 1, S_MODE, 8'hE4, "R1 mask");
    push(n + 1, S_SRST, 8'h00, "R3 no fire 0->1");

    do_write(8'hE4, n);                       // R3 1 over 1
    push(n + 1, S_SRST, 8'h00, "R3 hold1 srst");
    push(n + 1, S_SUSP, 8'h00, "R3 hold1 susp");
    push(n + 1, S_BUSY, 8'h00, "R3 hold1 busy");

    @(negedge clk); clk_stable = 1'b0;        // R2 dropped write
    do_write(8'h00, n);
    push(n + 1, S_ERR,  8'h01, "R2 flag");
    push(n + 1, S_MODE, 8'hE4, "R2 hold");
    push(n + 1, S_SRST, 8'h00, "R2 no fire");
    push(n + 1, S_BUSY, 8'h00, "R2 no resume");
    push(n + 2, S_ERR,  8'h00, "R2 one cycle");
    @(negedge clk); clk_stable = 1'b1;

    do_write(8'hA4, n);                       // R6 suspend fire
    push(n + 1, S_SUSP, 8'h01, "R6 suspend");
    push(n + 1, S_MODE, 8'hA4, "R1 readback");
    push(n + 1, S_SRST, 8'h00, "R3 srst held");

    do_read(n);                               // R8 wake, R7 exit
    push(n + 1, S_WAKE, 8'h01, "R8 wake");
    push(n + 1, S_SUSP, 8'h00, "R7 read exits");
    push(n + 2, S_WAKE, 8'h00, "R8 one cycle");

    do_write(8'hE0, n);
    do_write(8'hA0, n);
    push(n + 1, S_SUSP, 8'h01, "R6 suspend again");
    do_read(n);                               // R8 disabled
    push(n + 1, S_WAKE, 8'h00, "R8 wake disabled");
    push(n + 1, S_SUSP, 8'h00, "R7 read exits 2");

    do_write(8'hE0, n);
    do_write(8'hA0, n);
    do_write(8'h20, n);                       // R4 resume fire
    push(n + 1, S_SUSP, 8'h00, "R7 resume exits");
    push(n + 1, S_BUSY, 8'h01, "R4 busy rise");
    push(n + DELAY, S_DRV, 8'h00, "R4 delay");
    push(n + DELAY + 1, S_DRV, 8'h01, "R4 drive rise");
    push(n + DELAY + DRIVE, S_DRV, 8'h01, "R4 drive hold");
    push(n + DELAY + DRIVE, S_BUSY, 8'h01, "R5 busy kept");
    push(n + DELAY + DRIVE + 1, S_DRV, 8'h00, "R5 drive end");
    push(n + DELAY + DRIVE + 1, S_BUSY, 8'h00, "R4 busy fall");
    do_write(8'hA0, tmp);                     // R5 refire while busy
    do_write(8'h20, tmp);
    push(tmp + 1, S_SRST, 8'h00, "R5 no srst");
    wait_until(n + DELAY + DRIVE + 5);

    do_write(8'hA0, n);                       // R9 abort mid-resume
    do_write(8'h20, n);
    push(n + 1, S_BUSY, 8'h01, "R4 busy again");
    wait_until(n + 50);
    do_write(8'h60, n);
    do_write(8'h20, n);
    push(n + 1, S_SUSP, 8'h01, "R6 suspend in resume");
    do_write(8'h00, n);
    push(n + 1, S_SRST, 8'h01, "R9 pulse");
    push(n + 1, S_SUSP, 8'h00, "R9 clears suspend");
    push(n + 1, S_BUSY, 8'h00, "R9 aborts busy");
    push(n + 1, S_DRV,  8'h00, "R9 no drive");
    push(n + 2, S_SRST, 8'h00, "R9 single cycle");
    push(n + DELAY + 10, S_DRV, 8'h00, "R9 stays aborted");
    wait_until(n + DELAY + 12);

    do_write(8'hE0, n);                       // R10 all fire together
    do_write(8'h00, n);
    push(n + 1, S_SRST, 8'h01, "R10 srst");
    push(n + 1, S_SUSP, 8'h00, "R10 no suspend");
    push(n + 1, S_BUSY, 8'h00, "R10 no resume");
    push(n + 3, S_BUSY, 8'h00, "R10 still idle");
    push(n + 3, S_SUSP, 8'h00, "R10 still awake");
    wait_until(n + 6);

    if (sb.size() != 0) begin
      checks++; errs++;
      $display("FAIL pending actual=%0d expected=0", sb.size());
    end
    finish_run();
  end
endmodule